// File: doc/BRIEF.md
# Context-Switch Microcode Sequencer

This block runs a small host-loaded microprogram that steers saving and restoring of graphics-engine state. The host fills a program store of up to 256 words. It does this by writing a start index and then streaming words into a data register. The host also sets request flags. A start pulse then runs the program from address 0. Each cycle the sequencer executes one word. It can branch on a single flag, stall until a flag takes a required value, write a flag, or load a 20-bit count register. It can also issue a register-block transfer to the external state-transfer datapath and wait for that datapath's acknowledge. It also emits a one-cycle strobe for each of the special command words.

The flags form a file of 128 single bits, numbered group*32 + bit. Flag 0 is the transfer direction, where 1 means save and 0 means load. Flag 5 is the user-save request and flag 6 is the user-load request. Flag 96 mirrors the engine-busy input. Flag 100 is the auto-save request, flag 101 is the auto-load request, and flag 104 is constant-true. A microprogram decides between saving, loading or simply exiting by testing these flags. It then clears the user requests and ends.

The sequencer has four states. In ST_IDLE it waits for start. In ST_EXEC it executes one word per cycle. In ST_XFER it holds a transfer request until it is acknowledged. In ST_HALT it has stopped on an illegal word. The transitions are as follows:
- ST_IDLE or ST_HALT moves to ST_EXEC on start.
- ST_EXEC moves to ST_XFER on a transfer word.
- ST_XFER returns to ST_EXEC on acknowledge.
- ST_EXEC moves to ST_IDLE on the end command.
- ST_EXEC moves to ST_HALT on an unrecognised word.

Top module: `ctxseq_top`

## Requirements
- R1: A write on host_index_we loads the store index from host_wdata[7:0]. Each host_data_we write stores host_wdata at the index and then increments the index by one. A program loaded this way is the one that executes.
- R2: A word with bits 23:20 = 1 is a block transfer. It raises xfer_req with xfer_cnt = bits 19:14 and xfer_reg = bits 13:0, and xfer_dir follows flag 0. The request and its fields stay stable until xfer_ack is seen. The next word executes only after the acknowledge.
- R3: A word with bits 23:20 = 2 loads bits 19:0 into lsr_value, which is 0 after reset.
- R4: A word with bits 23:20 = 4 is a branch to the address in bits 15:8. With bit 7 = 0 it is taken when the flag selected by bits 6:0 is 1. With bit 7 = 1 it is taken when that flag is 0. Otherwise execution falls through to the next address.
- R5: A word with bits 23:20 = 5 stalls execution until the flag selected by bits 6:0 equals bit 7. While it stalls, no transfer or strobe is issued.
- R6: A word with bits 23:20 = 7 writes bit 7 into the flag selected by bits 6:0. The written value is visible on host_flag_rdata.
- R7: host_flag_rdata returns the flag selected by host_flag_sel. Flag 96 always reads engine_busy and flag 104 always reads 1. Host writes to either of these flags have no effect.
- R8: The words 0x00600007, 0x00600009 and 0x0060000A each pulse stb_next_swap, stb_next_cur and stb_set_ptr respectively, for one cycle. At most one of the strobes and done is high in any cycle.
- R9: The word 0x0060000E pulses done for one cycle and returns the sequencer to idle. A later start runs the program again from address 0.
- R10: Any other opcode, any other command in the 6 group, or any word with bits 31:24 non-zero raises a sticky error and halts the sequencer. The error stays set until the next start, which clears it and restarts the program at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_index_we | input | 1 | Load store index from host_wdata[7:0] |
| host_data_we | input | 1 | Store host_wdata at index, then increment index |
| host_wdata | input | 32 | Host write data |
| host_flag_we | input | 1 | Host flag write |
| host_flag_sel | input | 7 | Flag number for host read and write |
| host_flag_val | input | 1 | Value for host flag write |
| host_flag_rdata | output | 1 | Value of flag host_flag_sel |
| engine_busy | input | 1 | Engine busy status, seen as flag 96 |
| start | input | 1 | Start the program from address 0 |
| running | output | 1 | Sequencer is executing or transferring |
| done | output | 1 | One-cycle pulse on end command |
| error | output | 1 | Sticky illegal-word indication |
| xfer_req | output | 1 | Register-block transfer request |
| xfer_dir | output | 1 | Transfer direction (flag 0, 1 = save) |
| xfer_reg | output | 14 | First register index of transfer |
| xfer_cnt | output | 6 | Word count of transfer |
| xfer_ack | input | 1 | Transfer completion acknowledge |
| lsr_value | output | 20 | Count register |
| stb_next_swap | output | 1 | Next-to-swap command strobe |
| stb_next_cur | output | 1 | Next-to-current command strobe |
| stb_set_ptr | output | 1 | Set-context-pointer command strobe |

## Verification
The assertions assume that xfer_ack arrives only while xfer_req is high and lasts a single cycle. They also assume that the host does not write flags or the store while running is high. The bench keeps to these assumptions. Its acknowledge responder raises xfer_ack for exactly one cycle, after a random delay, for each request it sees. All host writes, and the random choice of request flags and busy duration, happen only between runs, while the sequencer is idle.

// File: rtl/ctxseq_pkg.sv
package ctxseq_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;
    localparam int FLAG_W = 7;
    localparam int CNT_W  = 20;
    localparam int XREG_W = 14;
    localparam int XCNT_W = 6;
    localparam int FL_BUSY = 96;
    localparam int FL_TRUE = 104;

    typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_XFER, ST_HALT} seq_state_t;

    localparam logic [3:0] OP_XFER = 4'h1;
    localparam logic [3:0] OP_LSR  = 4'h2;
    localparam logic [3:0] OP_BRA  = 4'h4;
    localparam logic [3:0] OP_WAIT = 4'h5;
    localparam logic [3:0] OP_CMD  = 4'h6;
    localparam logic [3:0] OP_SET  = 4'h7;

    localparam logic [19:0] CMD_SWAP = 20'h00007;
    localparam logic [19:0] CMD_CUR  = 20'h00009;
    localparam logic [19:0] CMD_PTR  = 20'h0000A;
    localparam logic [19:0] CMD_END  = 20'h0000E;
endpackage

// File: rtl/ctxseq_store.sv
module ctxseq_store #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_we,
    input  logic              data_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx <= '0;
        else if (idx_we)
            idx <= wdata[ADDR_W-1:0];
        else if (data_we)
            idx <= idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (data_we && !idx_we)
            mem[idx] <= wdata;
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/ctxseq_flags.sv
module ctxseq_flags #(
    parameter int FLAG_W   = 7,
    parameter int BUSY_IDX = 96,
    parameter int TRUE_IDX = 104
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              engine_busy,
    input  logic              seq_we,
    input  logic [FLAG_W-1:0] seq_sel,
    input  logic              seq_val,
    input  logic              host_we,
    input  logic [FLAG_W-1:0] host_sel,
    input  logic              host_val,
    output logic              seq_rval,
    output logic              host_rval,
    output logic              dir
);
    localparam int NFLAG = 1 << FLAG_W;

    logic [NFLAG-1:0] fval;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        if (i == BUSY_IDX) begin : g_busy
            assign fval[i] = engine_busy;
        end else if (i == TRUE_IDX) begin : g_true
            assign fval[i] = 1'b1;
        end else begin : g_store
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (seq_we && seq_sel == FLAG_W'(i))
                    bit_q <= seq_val;
                else if (host_we && host_sel == FLAG_W'(i))
                    bit_q <= host_val;
            end
            assign fval[i] = bit_q;
        end
    end

    assign seq_rval  = fval[seq_sel];
    assign host_rval = fval[host_sel];
    assign dir       = fval[0];
endmodule

// File: rtl/ctxseq_fsm.sv
module ctxseq_fsm
    import ctxseq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic              flag_val,
    input  logic              xfer_ack,
    output logic [ADDR_W-1:0] pc,
    output logic              seq_we,
    output logic              seq_val,
    output logic              xfer_req,
    output logic [13:0]       xfer_reg,
    output logic [5:0]        xfer_cnt,
    output logic [19:0]       lsr_value,
    output logic              stb_next_swap,
    output logic              stb_next_cur,
    output logic              stb_set_ptr,
    output logic              done,
    output logic              error,
    output logic              running
);
    seq_state_t state, nxt;

    logic [3:0]  op;
    logic [19:0] cmd;
    logic        hi_ok, pol, legal, is_end, is_swap, is_cur, is_ptr, in_exec;

    assign op      = instr[23:20];
    assign cmd     = instr[19:0];
    assign pol     = instr[7];
    assign hi_ok   = (instr[31:24] == 8'h00);
    assign in_exec = (state == ST_EXEC);
    assign is_swap = hi_ok && op == OP_CMD && cmd == CMD_SWAP;
    assign is_cur  = hi_ok && op == OP_CMD && cmd == CMD_CUR;
    assign is_ptr  = hi_ok && op == OP_CMD && cmd == CMD_PTR;
    assign is_end  = hi_ok && op == OP_CMD && cmd == CMD_END;

    always_comb begin
        legal = 1'b0;
        if (hi_ok) begin
            unique case (op)
                OP_XFER, OP_LSR, OP_BRA, OP_WAIT, OP_SET: legal = 1'b1;
                OP_CMD:  legal = is_swap || is_cur || is_ptr || is_end;
                default: legal = 1'b0;
            endcase
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_HALT: if (start) nxt = ST_EXEC;
            ST_EXEC: begin
                if (!legal)                nxt = ST_HALT;
                else if (op == OP_XFER)    nxt = ST_XFER;
                else if (is_end)           nxt = ST_IDLE;
            end
            ST_XFER: if (xfer_ack) nxt = ST_EXEC;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc            <= '0;
            xfer_reg      <= '0;
            xfer_cnt      <= '0;
            lsr_value     <= '0;
            error         <= 1'b0;
            done          <= 1'b0;
            stb_next_swap <= 1'b0;
            stb_next_cur  <= 1'b0;
            stb_set_ptr   <= 1'b0;
        end else begin
            done          <= in_exec && is_end;
            stb_next_swap <= in_exec && is_swap;
            stb_next_cur  <= in_exec && is_cur;
            stb_set_ptr   <= in_exec && is_ptr;
            unique case (state)
                ST_IDLE, ST_HALT: begin
                    if (start) begin
                        pc    <= '0;
                        error <= 1'b0;
                    end
                end
                ST_EXEC: begin
                    if (!legal) begin
                        error <= 1'b1;
                    end else begin
                        unique case (op)
                            OP_XFER: begin
                                xfer_reg <= instr[13:0];
                                xfer_cnt <= instr[19:14];
                            end
                            OP_LSR: begin
                                lsr_value <= cmd;
                                pc        <= pc + 1'b1;
                            end
                            OP_BRA:  pc <= (flag_val != pol) ? instr[8 +: ADDR_W] : pc + 1'b1;
                            OP_WAIT: if (flag_val == pol) pc <= pc + 1'b1;
                            default: if (!is_end) pc <= pc + 1'b1;
                        endcase
                    end
                end
                ST_XFER: if (xfer_ack) pc <= pc + 1'b1;
                default: ;
            endcase
        end
    end

    assign seq_we   = in_exec && hi_ok && op == OP_SET;
    assign seq_val  = pol;
    assign xfer_req = (state == ST_XFER);
    assign running  = in_exec || xfer_req;
endmodule

// File: rtl/ctxseq_top.sv
module ctxseq_top
    import ctxseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_index_we,
    input  logic        host_data_we,
    input  logic [31:0] host_wdata,
    input  logic        host_flag_we,
    input  logic [6:0]  host_flag_sel,
    input  logic        host_flag_val,
    output logic        host_flag_rdata,
    input  logic        engine_busy,
    input  logic        start,
    output logic        running,
    output logic        done,
    output logic        error,
    output logic        xfer_req,
    output logic        xfer_dir,
    output logic [13:0] xfer_reg,
    output logic [5:0]  xfer_cnt,
    input  logic        xfer_ack,
    output logic [19:0] lsr_value,
    output logic        stb_next_swap,
    output logic        stb_next_cur,
    output logic        stb_set_ptr
);
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] instr;
    logic              flag_val, seq_we, seq_val;

    ctxseq_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .idx_we(host_index_we), .data_we(host_data_we), .wdata(host_wdata),
        .rd_addr(pc), .rd_word(instr)
    );

    ctxseq_flags #(.FLAG_W(FLAG_W), .BUSY_IDX(FL_BUSY), .TRUE_IDX(FL_TRUE)) u_flags (
        .clk(clk), .rst_n(rst_n), .engine_busy(engine_busy),
        .seq_we(seq_we), .seq_sel(instr[FLAG_W-1:0]), .seq_val(seq_val),
        .host_we(host_flag_we), .host_sel(host_flag_sel), .host_val(host_flag_val),
        .seq_rval(flag_val), .host_rval(host_flag_rdata), .dir(xfer_dir)
    );

    ctxseq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .flag_val(flag_val), .xfer_ack(xfer_ack), .pc(pc),
        .seq_we(seq_we), .seq_val(seq_val),
        .xfer_req(xfer_req), .xfer_reg(xfer_reg), .xfer_cnt(xfer_cnt),
        .lsr_value(lsr_value),
        .stb_next_swap(stb_next_swap), .stb_next_cur(stb_next_cur),
        .stb_set_ptr(stb_set_ptr),
        .done(done), .error(error), .running(running)
    );
endmodule

// File: rtl/ctxseq_chk.sv
module ctxseq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [6:0]  host_flag_sel,
    input logic        host_flag_rdata,
    input logic        engine_busy,
    input logic        start,
    input logic        running,
    input logic        done,
    input logic        error,
    input logic        xfer_req,
    input logic [13:0] xfer_reg,
    input logic [5:0]  xfer_cnt,
    input logic        xfer_ack,
    input logic        stb_next_swap,
    input logic        stb_next_cur,
    input logic        stb_set_ptr
);
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_reg) && $stable(xfer_cnt));

    a_r2_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && xfer_ack |=> !xfer_req);

    a_r8_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stb_next_swap, stb_next_cur, stb_set_ptr, done}));

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error && !start |=> error);

    a_r10_err_halted: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !running && !xfer_req);

    a_r7_busy_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        host_flag_sel == 7'd96 |-> host_flag_rdata == engine_busy);
endmodule

bind ctxseq_top ctxseq_chk u_chk (.*);

// File: tb/ctxseq_top_tb.sv
module ctxseq_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_index_we = 1'b0, host_data_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_flag_we = 1'b0;
    logic [6:0]  host_flag_sel = '0;
    logic        host_flag_val = 1'b0;
    logic        host_flag_rdata;
    logic        engine_busy;
    logic        start = 1'b0;
    logic        running, done, error, xfer_req, xfer_dir;
    logic [13:0] xfer_reg;
    logic [5:0]  xfer_cnt;
    logic        xfer_ack = 1'b0;
    logic [19:0] lsr_value;
    logic        stb_next_swap, stb_next_cur, stb_set_ptr;

    ctxseq_top u_dut (.*);

    always #5 clk = ~clk;

    int checks = 0, failures = 0, cycles = 0;
    int busy_left = 0, ack_wait = 0;
    logic [31:0] prog [256];
    logic [31:0] act [64];
    logic [31:0] exp_ev [64];
    int act_n = 0, exp_n = 0;
    bit done_seen = 0;
    logic [19:0] exp_lsr = '0;

    assign engine_busy = (busy_left != 0);

    task automatic chk(input bit ok, input string req, input int a, input int e);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, a, e);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // acknowledge responder and event monitor
    always @(negedge clk) begin
        cycles++;
        if (busy_left > 0) busy_left--;
        if (xfer_ack) begin
            xfer_ack = 1'b0;
            ack_wait = $urandom % 4;
        end else if (xfer_req) begin
            if (ack_wait == 0) begin
                xfer_ack = 1'b1;
                if (act_n < 64) act[act_n] = 32'h0100_0000 | ({31'b0, xfer_dir} << 20)
                                             | ({26'b0, xfer_cnt} << 14) | {18'b0, xfer_reg};
                act_n++;
            end else ack_wait--;
        end
        if (stb_next_swap || stb_next_cur || stb_set_ptr) begin
            if (act_n < 64) act[act_n] = 32'h0200_0000 | (stb_next_swap ? 7 : stb_next_cur ? 9 : 10);
            act_n++;
        end
        if (done) done_seen = 1;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    function automatic logic [31:0] w_bra(int tgt, bit ifclr, int fl);
        return 32'h0040_0000 | (tgt << 8) | ({31'b0, ifclr} << 7) | fl;
    endfunction
    function automatic logic [31:0] w_wait(bit pol, int fl);
        return 32'h0050_0000 | ({31'b0, pol} << 7) | fl;
    endfunction
    function automatic logic [31:0] w_set(bit v, int fl);
        return 32'h0070_0000 | ({31'b0, v} << 7) | fl;
    endfunction
    function automatic logic [31:0] w_xfer(int cnt, int rg);
        return 32'h0010_0000 | (cnt << 14) | rg;
    endfunction

    task automatic host_word(input logic [31:0] w);
        @(negedge clk); host_data_we = 1'b1; host_wdata = w;
        @(negedge clk); host_data_we = 1'b0;
    endtask
    task automatic host_index(input int i);
        @(negedge clk); host_index_we = 1'b1; host_wdata = i;
        @(negedge clk); host_index_we = 1'b0;
    endtask
    task automatic host_flag(input int sel, input bit v);
        @(negedge clk); host_flag_we = 1'b1; host_flag_sel = sel[6:0]; host_flag_val = v;
        @(negedge clk); host_flag_we = 1'b0;
    endtask
    task automatic read_flag(input int sel, output bit v);
        @(negedge clk); host_flag_sel = sel[6:0]; #1 v = host_flag_rdata;
    endtask

    // instruction-level reference model
    task automatic model(input bit as_, us, al, ul);
        bit mf [128];
        int pc = 0;
        logic [31:0] w;
        for (int i = 0; i < 128; i++) mf[i] = 0;
        mf[100] = as_; mf[5] = us; mf[101] = al; mf[6] = ul; mf[104] = 1;
        exp_n = 0;
        for (int step = 0; step < 300; step++) begin
            w = prog[pc];
            if (w[31:24] != 0) break;
            case (w[23:20])
                4'h1: begin exp_ev[exp_n] = 32'h0100_0000 | ({31'b0, mf[0]} << 20) | w[19:0];
                            exp_n++; pc++; end
                4'h2: begin exp_lsr = w[19:0]; pc++; end
                4'h4: pc = (mf[w[6:0]] != w[7]) ? int'(w[15:8]) : pc + 1;
                4'h5: pc++;
                4'h7: begin mf[w[6:0]] = w[7]; pc++; end
                4'h6: begin
                    if (w[19:0] == 20'hE) break;
                    exp_ev[exp_n] = 32'h0200_0000 | w[19:0]; exp_n++; pc++;
                end
                default: break;
            endcase
            pc = pc % 256;
        end
    endtask

    task automatic run_case(input bit as_, us, al, ul, input int busy, input bit stall_chk, input string tag);
        bit v;
        host_flag(100, as_); host_flag(5, us); host_flag(101, al); host_flag(6, ul); host_flag(0, 0);
        model(as_, us, al, ul);
        act_n = 0; done_seen = 0;
        @(negedge clk); busy_left = busy; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (stall_chk) begin
            repeat (20) @(negedge clk);
            chk(act_n == 0 && running == 1'b1, "R5 stall while busy", act_n, 0);
        end
        for (int t = 0; t < 4000 && !done_seen; t++) @(negedge clk);
        chk(done_seen && !running, {"R9 done ", tag}, int'(done_seen), 1);
        chk(act_n == exp_n, {"R2 R8 event count ", tag}, act_n, exp_n);
        for (int i = 0; i < exp_n && i < act_n; i++)
            chk(act[i] == exp_ev[i], {"R2 R4 R8 event order ", tag}, int'(act[i]), int'(exp_ev[i]));
        chk(lsr_value == exp_lsr, {"R3 count reg ", tag}, int'(lsr_value), int'(exp_lsr));
        read_flag(5, v); chk(v == 0, {"R6 user save cleared ", tag}, int'(v), 0);
        read_flag(6, v); chk(v == 0, {"R6 user load cleared ", tag}, int'(v), 0);
        chk(error == 0, {"R10 no error ", tag}, int'(error), 0);
    endtask

    initial begin
        bit v;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) prog[i] = 32'h0;
        prog[0]  = w_bra(10, 0, 100);
        prog[1]  = w_bra(10, 0, 5);
        prog[2]  = w_bra(5, 0, 101);
        prog[3]  = w_bra(6, 0, 6);
        prog[4]  = w_bra(20, 0, 104);
        prog[5]  = 32'h0060_0007;
        prog[6]  = w_wait(0, 96);
        prog[7]  = w_set(0, 0);
        prog[8]  = w_bra(11, 0, 104);
        prog[10] = w_set(1, 0);
        prog[11] = w_xfer(3, 14'h100);
        prog[12] = 32'h0025_A5A5;
        prog[13] = w_xfer(5, 14'h2A0);
        prog[14] = w_bra(16, 1, 0);
        prog[15] = 32'h0060_000A;
        prog[16] = 32'h0060_0009;
        prog[17] = w_bra(20, 0, 104);
        prog[20] = w_set(0, 5);
        prog[21] = w_set(0, 6);
        prog[22] = 32'h0060_000E;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!running && !done && !error && !xfer_req, "R9 reset idle", int'(running), 0);
        chk(lsr_value == 0, "R3 reset count", int'(lsr_value), 0);

        host_index(0);
        for (int i = 0; i < 23; i++) host_word(prog[i]);

        // R7: busy mirror is read-only, constant-true reads 1
        host_flag(96, 1); read_flag(96, v); chk(v == 0, "R7 busy write ignored", int'(v), 0);
        host_flag(104, 0); read_flag(104, v); chk(v == 1, "R7 true flag", int'(v), 1);
        busy_left = 5; read_flag(96, v); chk(v == 1, "R7 busy mirror", int'(v), 1);
        repeat (6) @(negedge clk);
        host_flag(3, 1); read_flag(3, v); chk(v == 1, "R6 host flag store", int'(v), 1);

        // directed paths
        run_case(0, 0, 0, 0, 0, 0, "exit");
        run_case(1, 0, 0, 0, 0, 0, "auto save");
        run_case(0, 1, 0, 0, 0, 0, "user save");
        run_case(0, 0, 1, 0, 3, 0, "auto load");
        run_case(0, 0, 0, 1, 40, 1, "R5 user load stall");
        run_case(1, 0, 0, 1, 0, 0, "save over load");

        // R1: re-index reload of words 12 and 13
        prog[12] = 32'h0020_ABCD;
        prog[13] = w_xfer(7, 14'h3FFF);
        host_index(12); host_word(prog[12]); host_word(prog[13]);
        run_case(0, 1, 0, 0, 0, 0, "R1 reload");

        // random
        for (int r = 0; r < 24; r++) begin
            logic [3:0] f = 4'($urandom);
            run_case(f[0], f[1], f[2], f[3], $urandom % 30, 0, "random");
        end

        // R10: illegal opcode, then illegal high byte, then restart clears
        host_index(0); host_word(32'h0030_0000);
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        chk(error && !running, "R10 illegal opcode halts", int'(error), 1);
        host_index(0); host_word(32'h0120_0000);
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        chk(error && !running, "R10 high byte halts", int'(error), 1);
        repeat (5) @(negedge clk);
        chk(error == 1, "R10 error sticky", int'(error), 1);
        host_index(0); host_word(prog[0]);
        run_case(0, 0, 0, 0, 0, 0, "R10 restart clears");

        finish_run();
    end
endmodule